// File: doc/BRIEF.md
# Key-Locked System Flag and Reset Register Block

This block is a small set of control registers on a 32-bit register bus with a 4 KB address window. It holds two banks of software flags. Each bank is read at one address and written through separate set and clear addresses. The first bank is volatile. The second survives a soft (system) reset and is cleared only by power-on reset. The block also holds a reset-control register, a lock register and a free-running tick counter. The counter advances at a fixed fraction of the bus clock (24 MHz by default).

Writes to reset control are refused unless software first opens the lock by writing the unlock key 0x0000A05F to the lock register. An accepted reset-control write raises `rst_req` for one cycle, which the system uses to start a soft reset.

Two small state machines hold the control state:

- **Lock machine.** States are `LK_SHUT` and `LK_OPEN`.
  - `SHUT->OPEN`: a write of the key to the lock register.
  - `OPEN->SHUT` (or `SHUT->SHUT`): a write of any other value to the lock register.
  - Any other cycle: the state holds.
- **Request machine.** States are `RQ_IDLE` and `RQ_FIRE`.
  - `IDLE->FIRE` (or `FIRE->FIRE`): an accepted reset-control write.
  - `FIRE->IDLE`: any other cycle.
  - `rst_req` is 1 exactly in `RQ_FIRE`.

Top module: `sysflag_regs`

## Requirements
- R1: After power-on reset, `rst_req` is 0 and every mapped register reads 0, except the lock register, which reads 0x00010000 (locked indicator set).
- R2: Writing exactly 0x0000A05F to offset 0x020 opens the lock. Offset 0x020 then reads 0x0000A05F, with bit 16 (the locked indicator) at 0.
- R3: Writing any other 32-bit value to offset 0x020 closes the lock. The stored value is the data's bits 14:0 with bit 15 forced to 0. A read returns that value in bits 15:0 and 1 in bit 16.
- R4: A write to offset 0x030 ORs the data into the volatile flags. Offset 0x030 reads the flags.
- R5: A write to offset 0x034 clears the volatile flag bits that are 1 in the data.
- R6: The non-volatile flags behave as in R4 and R5: set at offset 0x038, clear at offset 0x03C, read at offset 0x038.
- R7: While the lock is open, a write to offset 0x040 stores data bits 7:0, which read back zero-extended at 0x040. It also drives `rst_req` to 1 for the one cycle after the write edge.
- R8: While the lock is closed, a write to offset 0x040 does not change the stored value and leaves `rst_req` at 0.
- R9: Offset 0x05C reads a counter that advances by exactly TICK_HZ counts every CLK_HZ clock cycles, never by more than 1 per cycle. With the defaults this is 24 counts per 250 cycles.
- R10: Reads of unmapped offsets, including the clear-only aliases 0x034 and 0x03C, return 0. Writes to unmapped offsets change no register and raise no request.
- R11: A low `sys_rst_n` returns the volatile flags, lock, reset control and counter to their power-on values, but keeps the non-volatile flags.
- R12: A low `por_n` also clears the non-volatile flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low, clears all state |
| sys_rst_n | input | 1 | Asynchronous soft reset, active low, keeps non-volatile flags |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 12 | Byte offset in the window (word aligned) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | One-cycle soft reset request |

## Verification
Some behaviours are checked by assertions on every cycle:
- a key write opens the lock and any other lock write closes it;
- an accepted reset-control write is followed by `rst_req` in the next cycle, and a refused one is not;
- set and clear writes leave the written bits at 1 or 0 respectively;
- the counter never steps by more than one.

Other behaviours only the bench scenarios can show:
- the exact 15-bit masking of refused keys;
- the long-run counter rate;
- silence of unmapped writes across all registers;
- which registers survive each kind of reset.

// File: rtl/sysflag_pkg.sv
package sysflag_pkg;
    localparam logic [31:0] UNLOCK_KEY = 32'h0000_A05F;
    localparam logic [11:0] OFF_LOCK   = 12'h020;
    localparam logic [11:0] OFF_FSET   = 12'h030;
    localparam logic [11:0] OFF_FCLR   = 12'h034;
    localparam logic [11:0] OFF_NSET   = 12'h038;
    localparam logic [11:0] OFF_NCLR   = 12'h03C;
    localparam logic [11:0] OFF_RCTL   = 12'h040;
    localparam logic [11:0] OFF_TICK   = 12'h05C;

    typedef enum logic { LK_SHUT, LK_OPEN } lock_st_e;
    typedef enum logic { RQ_IDLE, RQ_FIRE } req_st_e;
endpackage

// File: rtl/sysflag_lock.sv
module sysflag_lock
    import sysflag_pkg::*;
#(
    parameter int KEY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [31:0]      wdata,
    output logic [KEY_W-1:0] val,
    output logic             open
);
    lock_st_e         st, st_nx;
    logic [KEY_W-1:0] val_nx;

    always_comb begin
        st_nx  = st;
        val_nx = val;
        if (wr) begin
            if (wdata == UNLOCK_KEY) begin
                st_nx  = LK_OPEN;
                val_nx = UNLOCK_KEY[KEY_W-1:0];
            end else begin
                st_nx  = LK_SHUT;
                val_nx = {1'b0, wdata[KEY_W-2:0]};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= LK_SHUT;
            val <= '0;
        end else begin
            st  <= st_nx;
            val <= val_nx;
        end
    end

    always_comb begin
        unique case (st)
            LK_OPEN: open = 1'b1;
            LK_SHUT: open = 1'b0;
            default: open = 1'b0;
        endcase
    end
endmodule

// File: rtl/sysflag_bits.sv
module sysflag_bits #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (set_we) q <= q | d;
        else if (clr_we) q <= q & ~d;
    end
endmodule

// File: rtl/sysflag_tick.sv
module sysflag_tick #(
    parameter int CLK_HZ  = 250_000_000,
    parameter int TICK_HZ = 24_000_000,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt
);
    localparam int ACC_W = $clog2(CLK_HZ + TICK_HZ) + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(TICK_HZ);
    localparam logic [ACC_W-1:0] WRAP = ACC_W'(CLK_HZ);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_sum;

    assign acc_sum = acc + STEP;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
        end else if (acc_sum >= WRAP) begin
            acc <= acc_sum - WRAP;
            cnt <= cnt + 1'b1;
        end else begin
            acc <= acc_sum;
        end
    end
endmodule

// File: rtl/sysflag_regs.sv
module sysflag_regs
    import sysflag_pkg::*;
#(
    parameter int FLAG_W  = 32,
    parameter int RCTL_W  = 8,
    parameter int KEY_W   = 16,
    parameter int CLK_HZ  = 250_000_000,
    parameter int TICK_HZ = 24_000_000
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        sys_rst_n,
    input  logic        wr_en,
    input  logic [11:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        rst_req
);
    localparam int WA = 10;

    logic              soft_n;
    logic [WA-1:0]     wa;
    logic              we_lock, we_fset, we_fclr, we_nset, we_nclr, we_rctl;
    logic [KEY_W-1:0]  lock_val;
    logic              lock_open;
    logic [FLAG_W-1:0] flags_q, nv_q;
    logic [RCTL_W-1:0] rctl_q;
    logic [31:0]       tick_q;
    logic              rctl_ok;
    req_st_e           rq_st, rq_nx;

    assign soft_n = por_n & sys_rst_n;
    assign wa     = addr[11:2];

    assign we_lock = wr_en && (wa == OFF_LOCK[11:2]);
    assign we_fset = wr_en && (wa == OFF_FSET[11:2]);
    assign we_fclr = wr_en && (wa == OFF_FCLR[11:2]);
    assign we_nset = wr_en && (wa == OFF_NSET[11:2]);
    assign we_nclr = wr_en && (wa == OFF_NCLR[11:2]);
    assign we_rctl = wr_en && (wa == OFF_RCTL[11:2]);
    assign rctl_ok = we_rctl && lock_open;

    sysflag_lock #(.KEY_W(KEY_W)) u_lock (
        .clk(clk), .rst_n(soft_n), .wr(we_lock), .wdata(wdata),
        .val(lock_val), .open(lock_open)
    );

    sysflag_bits #(.W(FLAG_W)) u_flags (
        .clk(clk), .rst_n(soft_n), .set_we(we_fset), .clr_we(we_fclr),
        .d(wdata[FLAG_W-1:0]), .q(flags_q)
    );

    sysflag_bits #(.W(FLAG_W)) u_nvflags (
        .clk(clk), .rst_n(por_n), .set_we(we_nset), .clr_we(we_nclr),
        .d(wdata[FLAG_W-1:0]), .q(nv_q)
    );

    sysflag_tick #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .CNT_W(32)) u_tick (
        .clk(clk), .rst_n(soft_n), .cnt(tick_q)
    );

    always_ff @(posedge clk or negedge soft_n) begin
        if (!soft_n)      rctl_q <= '0;
        else if (rctl_ok) rctl_q <= wdata[RCTL_W-1:0];
    end

    always_comb begin
        unique case (rq_st)
            RQ_IDLE: rq_nx = rctl_ok ? RQ_FIRE : RQ_IDLE;
            RQ_FIRE: rq_nx = rctl_ok ? RQ_FIRE : RQ_IDLE;
            default: rq_nx = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge soft_n) begin
        if (!soft_n) rq_st <= RQ_IDLE;
        else         rq_st <= rq_nx;
    end

    always_comb begin
        unique case (rq_st)
            RQ_FIRE: rst_req = 1'b1;
            RQ_IDLE: rst_req = 1'b0;
            default: rst_req = 1'b0;
        endcase
    end

    always_comb begin
        rdata = '0;
        unique case (wa)
            OFF_LOCK[11:2]: begin
                rdata[KEY_W-1:0] = lock_val;
                rdata[KEY_W]     = ~lock_open;
            end
            OFF_FSET[11:2]: rdata[FLAG_W-1:0] = flags_q;
            OFF_NSET[11:2]: rdata[FLAG_W-1:0] = nv_q;
            OFF_RCTL[11:2]: rdata[RCTL_W-1:0] = rctl_q;
            OFF_TICK[11:2]: rdata = tick_q;
            default:        rdata = '0;
        endcase
    end
endmodule

// File: rtl/sysflag_regs_chk.sv
module sysflag_regs_chk
    import sysflag_pkg::*;
#(
    parameter int FLAG_W = 32
) (
    input logic              clk,
    input logic              por_n,
    input logic              sys_rst_n,
    input logic              wr_en,
    input logic [11:0]       addr,
    input logic [31:0]       wdata,
    input logic              rst_req,
    input logic              lock_open,
    input logic [FLAG_W-1:0] flags_q,
    input logic [31:0]       tick_q
);
    // R2
    key_open_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (wr_en && addr == OFF_LOCK && wdata == UNLOCK_KEY) |=> lock_open);

    // R3
    key_shut_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (wr_en && addr == OFF_LOCK && wdata != UNLOCK_KEY) |=> !lock_open);

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (wr_en && addr == OFF_FSET) |=>
            ((flags_q & $past(wdata[FLAG_W-1:0])) == $past(wdata[FLAG_W-1:0])));

    // R5
    flag_clr_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (wr_en && addr == OFF_FCLR) |=> ((flags_q & $past(wdata[FLAG_W-1:0])) == '0));

    // R7
    rctl_fire_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (wr_en && addr == OFF_RCTL && lock_open) |=> rst_req);

    // R8
    rctl_block_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (wr_en && addr == OFF_RCTL && !lock_open) |=> !rst_req);

    // R9
    tick_step_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (tick_q == $past(tick_q)) || (tick_q == $past(tick_q) + 32'd1));
endmodule

bind sysflag_regs sysflag_regs_chk #(.FLAG_W(FLAG_W)) u_chk (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rst_req(rst_req), .lock_open(lock_open),
    .flags_q(flags_q), .tick_q(tick_q)
);

// File: tb/sysflag_regs_tb.sv
module sysflag_regs_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sysflag_regs u_dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        logic [31:0] fm, nm, t0, t1, d;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        #1;
        // R1 power-on state
        chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
        rd_chk("R1 lock", 12'h020, 32'h0001_0000);
        rd_chk("R1 flags", 12'h030, 32'h0);
        rd_chk("R1 nvflags", 12'h038, 32'h0);
        rd_chk("R1 rctl", 12'h040, 32'h0);
        rd_chk("R1 tick", 12'h05C, 32'h0);
        // R10 unmapped reads
        rd_chk("R10 rd 000", 12'h000, 32'h0);
        rd_chk("R10 rd 034", 12'h034, 32'h0);
        rd_chk("R10 rd 03C", 12'h03C, 32'h0);
        rd_chk("R10 rd FFC", 12'hFFC, 32'h0);

        // R4 R5 R6 sweeps over every bit position
        fm = '0; nm = '0;
        for (int i = 0; i < 32; i++) begin
            d = (32'h1 << i) | (32'(i) * 32'h0101_0101);
            wr(12'h030, d); fm = fm | d;
            rd_chk("R4 set", 12'h030, fm);
            d = {d[15:0], d[31:16]} ^ (32'h1 << ((i * 7) % 32));
            wr(12'h034, d); fm = fm & ~d;
            rd_chk("R5 clr", 12'h034 - 12'h004, fm);
            d = ~(32'h1 << i) ^ (32'(i) << 9);
            wr(12'h038, d); nm = nm | d;
            rd_chk("R6 nv set", 12'h038, nm);
            d = 32'hF0F0_0F0F >> (i % 8);
            wr(12'h03C, d); nm = nm & ~d;
            rd_chk("R6 nv clr", 12'h038, nm);
        end

        // R3 near-key values stay locked and are masked
        for (int i = 0; i < 17; i++) begin
            d = UNLOCK_KEY_TB ^ (32'h1 << i);
            wr(12'h020, d);
            rd_chk("R3 lock masked", 12'h020, 32'h0001_0000 | (d & 32'h7FFF));
        end

        // R8 locked reset-control write refused
        wr(12'h040, 32'h55);
        chk("R8 no req", {31'b0, rst_req}, 32'h0);
        rd_chk("R8 rctl unchanged", 12'h040, 32'h0);

        // R2 open lock
        wr(12'h020, UNLOCK_KEY_TB);
        rd_chk("R2 lock open", 12'h020, 32'h0000_A05F);

        // R7 accepted write, single pulse, field masked
        wr(12'h040, 32'h1FF);
        chk("R7 req high", {31'b0, rst_req}, 32'h1);
        @(negedge clk); #1;
        chk("R7 req low", {31'b0, rst_req}, 32'h0);
        rd_chk("R7 rctl", 12'h040, 32'hFF);
        wr(12'h040, 32'h3C);
        chk("R7 req again", {31'b0, rst_req}, 32'h1);
        rd_chk("R7 rctl 2", 12'h040, 32'h3C);

        // R10 unmapped writes change nothing
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h024, 32'hFFFF_FFFF);
        wr(12'h044, 32'hFFFF_FFFF);
        wr(12'hFFC, 32'hFFFF_FFFF);
        #1;
        chk("R10 no req", {31'b0, rst_req}, 32'h0);
        rd_chk("R10 flags", 12'h030, fm);
        rd_chk("R10 nv", 12'h038, nm);
        rd_chk("R10 lock", 12'h020, 32'h0000_A05F);
        rd_chk("R10 rctl", 12'h040, 32'h3C);

        // R3 reclose: non-key write masks bit 15
        wr(12'h020, 32'h0001_A05F);
        rd_chk("R3 reclose", 12'h020, 32'h0001_205F);
        wr(12'h040, 32'h7);
        chk("R8 closed again", {31'b0, rst_req}, 32'h0);
        rd_chk("R8 rctl kept", 12'h040, 32'h3C);

        // R9 tick rate
        @(negedge clk);
        rd(12'h05C, t0);
        repeat (250) @(negedge clk);
        rd(12'h05C, t1);
        chk("R9 tick 250", t1 - t0, 32'd24);
        repeat (1000) @(negedge clk);
        rd(12'h05C, t0);
        chk("R9 tick 1000", t0 - t1, 32'd96);

        // R11 soft reset keeps nv flags
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
        #1;
        rd_chk("R11 flags", 12'h030, 32'h0);
        rd_chk("R11 lock", 12'h020, 32'h0001_0000);
        rd_chk("R11 rctl", 12'h040, 32'h0);
        rd_chk("R11 tick", 12'h05C, 32'h0);
        rd_chk("R11 nv kept", 12'h038, nm);

        // R12 power-on reset clears nv flags
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        #1;
        rd_chk("R12 nv", 12'h038, 32'h0);

        done = 1;
    end

    localparam logic [31:0] UNLOCK_KEY_TB = 32'h0000_A05F;

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (200000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule